// File: doc/BRIEF.md
# Clockless Two-Wire Stereo Audio Receiver

This block takes in a stereo serial audio stream that comes with no bit clock. It watches two lines. The channel-select line holds one level for each channel slot and changes level at the start of every slot. The data line carries the bits, most significant first, with 32 bit periods in each slot. The nominal bit rate is 2.8224 MHz (two channels at 44.1 kHz). The receiver runs from its own 48 MHz clock, which has no fixed relation to the stream. It rebuilds bit timing with a divide-by-17 phase counter, so one bit period is taken as 17 system clocks, about 0.04% off nominal.

Each change on the select line falls about 15% of the way into a bit window. The receiver uses that change to restart its phase counter and its slot bit index. At most 32 bit periods pass between two restarts. A word does not begin at the select change: it starts a set number of bit periods later, 3 by default. So each word runs across the next select change, and this is normal. Each completed word appears on the output together with the level of the select line at its first bit and a one-cycle strobe.

Top module: `lrsel_audio_rx`

## Requirements
- R1: After each change of the select line, the data line is sampled 6 system clocks (SAMPLE_POS) after the first clock edge that sees the new select level at the pin, and then every 17 clocks (BIT_CLKS). Each select change realigns this grid. No sample is taken before the first select change after reset.
- R2: Bits are shifted in most significant first. The first data bit of a word ends up in `word_o[31]` and the last one in `word_o[0]`.
- R3: A word starts at sample index SKIP_BITS (default 3) after a select change, counting samples from 0. It takes 32 consecutive samples, and these may run across the next select change.
- R4: `valid_o` is high for exactly one cycle per completed word. It rises two clocks after the clock edge that takes the word's last sample at the pin. `word_o` and `chan_o` change only together with `valid_o` and hold their values between strobes.
- R5: `chan_o` equals the select-line level (1 = high) at the word's first sample.
- R6: A synchronous active-high `rst` sets `word_o`, `chan_o`, `valid_o` and `frame_err_o` to 0. After reset no word is produced until a select change has been seen.
- R7: A select change can arrive while a word is partly shifted in. If the bits collected so far differ from 32 − SKIP_BITS, the partial word is dropped. `frame_err_o` then goes to 1 and stays at 1 until reset. Words received before and after the drop are unaffected.
- R8: A new word starts only at sample index SKIP_BITS of a slot. A slot longer than 32 bits therefore produces a single word, followed by no output until the next select change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock (48 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| lr_in | input | 1 | Asynchronous channel-select line |
| dat_in | input | 1 | Asynchronous serial data line |
| word_o | output | 32 | Last completed word, most significant bit first in time |
| chan_o | output | 1 | Select level at the first bit of `word_o` |
| valid_o | output | 1 | One-cycle strobe for a new word |
| frame_err_o | output | 1 | Sticky flag: a partial word was dropped |

## Verification
A phase counter that is off by one or two clocks moves every sample point. Against a stream whose bit windows are 17 clocks wide, this shows up in the very first word after a select change, either as changed bit values or as a `valid_o` strobe in the wrong cycle. An error in the slot bit index or the word bit count moves the start of the word. That corrupts every word from then on and changes how many strobes a long slot produces. A frame check that fires on a normal word crossing a select change raises `frame_err_o` within one slot of clean traffic. The bench compares the ports against a pin-level model on every clock, so any of these errors shows up in the cycle where it first affects an output.

// File: rtl/lrrx_pkg.sv
package lrrx_pkg;

   typedef enum logic {
      DS_HUNT  = 1'b0,
      DS_SHIFT = 1'b1
   } ds_state_t;

   // bits needed to hold values 0 .. n-1
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/lrrx_sync.sv
module lrrx_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lrrx_sync: STAGES must be at least 2");
   end

   // All lines share one depth, so they keep their relative timing.
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk) begin
      chain <= {chain[STAGES-2:0], d_in};
   end

   assign q_out = chain[STAGES-1];

endmodule

// File: rtl/lrrx_phase.sv
module lrrx_phase
   import lrrx_pkg::*;
#(
   parameter int unsigned BIT_CLKS   = 17,
   parameter int unsigned SAMPLE_POS = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic sel_edge,
   output logic tick
);

   localparam int unsigned CW = cnt_w(BIT_CLKS);
   localparam logic [CW-1:0] RELOAD = CW'(BIT_CLKS - 1);
   // Data and select pass through equal synchroniser depth, so the pin-level
   // offset needs only the one extra cycle taken by the select-delay flop.
   localparam logic [CW-1:0] FIRST = CW'(SAMPLE_POS - 1);

   if (BIT_CLKS < 4) begin : g_bad_bitclks
      $error("lrrx_phase: BIT_CLKS must be at least 4");
   end
   if (SAMPLE_POS < 2 || SAMPLE_POS >= BIT_CLKS) begin : g_bad_pos
      $error("lrrx_phase: SAMPLE_POS must lie in 2 .. BIT_CLKS-1");
   end

   logic [CW-1:0] cnt;
   logic          armed;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (sel_edge) begin
         cnt   <= FIRST;
         armed <= 1'b1;
      end else if (armed) begin
         cnt <= (cnt == '0) ? RELOAD : cnt - 1'b1;
      end
   end

   // an edge in the same cycle wins over a pending sample
   assign tick = armed && (cnt == '0) && !sel_edge;

   // checker: independent spacing counter
   logic [CW:0] chk_gap;
   logic        chk_prev;
   logic        chk_seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         chk_gap  <= '0;
         chk_prev <= 1'b0;
         chk_seen <= 1'b0;
      end else if (sel_edge) begin
         chk_gap  <= '0;
         chk_prev <= 1'b0;
         chk_seen <= 1'b1;
      end else if (tick) begin
         chk_gap  <= '0;
         chk_prev <= 1'b1;
      end else if (chk_gap != '1) begin
         chk_gap <= chk_gap + 1'b1;
      end
   end

   assert_tick_period_R1: assert property (@(posedge clk) disable iff (rst)
      (tick && chk_prev) |-> (chk_gap == (CW+1)'(BIT_CLKS - 1)));

   assert_first_tick_R1: assert property (@(posedge clk) disable iff (rst)
      (tick && !chk_prev) |-> (chk_gap == (CW+1)'(SAMPLE_POS - 1)));

   assert_no_tick_before_edge_R6: assert property (@(posedge clk) disable iff (rst)
      !chk_seen |-> !tick);

   assert_edge_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      sel_edge |=> !tick);

endmodule

// File: rtl/lrrx_deser.sv
module lrrx_deser
   import lrrx_pkg::*;
#(
   parameter int unsigned WORD_BITS = 32,
   parameter int unsigned SKIP_BITS = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sel_edge,
   input  logic                 tick,
   input  logic                 bit_in,
   input  logic                 lvl_in,
   output logic [WORD_BITS-1:0] word_o,
   output logic                 chan_o,
   output logic                 valid_o,
   output logic                 frame_err_o
);

   localparam int unsigned JMAX = WORD_BITS + SKIP_BITS + 1;
   localparam int unsigned JW   = cnt_w(JMAX + 1);
   localparam int unsigned BW   = cnt_w(WORD_BITS + 1);

   if (WORD_BITS < 2) begin : g_bad_width
      $error("lrrx_deser: WORD_BITS must be at least 2");
   end
   if (SKIP_BITS >= WORD_BITS) begin : g_bad_skip
      $error("lrrx_deser: SKIP_BITS must be below WORD_BITS");
   end

   ds_state_t            st;
   logic [JW-1:0]        slot_idx;
   logic [BW-1:0]        bcnt;
   logic [WORD_BITS-1:0] shreg;
   logic                 wchan;

   logic                 start;
   logic                 take;
   logic                 last;
   logic                 straddle_ok;
   logic [BW-1:0]        bcnt_nx;
   logic [WORD_BITS-1:0] sh_nx;

   // With a nonzero offset a word always crosses one select change with a
   // fixed number of bits already taken; with no offset it never crosses.
   if (SKIP_BITS > 0) begin : g_straddle
      assign straddle_ok = (bcnt == BW'(WORD_BITS - SKIP_BITS));
   end else begin : g_aligned
      assign straddle_ok = 1'b0;
   end

   always_comb begin
      start   = (st == DS_HUNT) && (slot_idx == JW'(SKIP_BITS));
      take    = (st == DS_SHIFT) || start;
      bcnt_nx = (start ? '0 : bcnt) + 1'b1;
      last    = (bcnt_nx == BW'(WORD_BITS));
      sh_nx   = {shreg[WORD_BITS-2:0], bit_in};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st          <= DS_HUNT;
         slot_idx    <= '0;
         bcnt        <= '0;
         shreg       <= '0;
         wchan       <= 1'b0;
         word_o      <= '0;
         chan_o      <= 1'b0;
         valid_o     <= 1'b0;
         frame_err_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (sel_edge) begin
            slot_idx <= '0;
            if (st == DS_SHIFT && !straddle_ok) begin
               st          <= DS_HUNT;
               bcnt        <= '0;
               frame_err_o <= 1'b1;
            end
         end else if (tick) begin
            if (slot_idx != JW'(JMAX)) begin
               slot_idx <= slot_idx + 1'b1;
            end
            if (take) begin
               shreg <= sh_nx;
               if (start) begin
                  wchan <= lvl_in;
               end
               if (last) begin
                  word_o  <= sh_nx;
                  chan_o  <= start ? lvl_in : wchan;
                  valid_o <= 1'b1;
                  st      <= DS_HUNT;
                  bcnt    <= '0;
               end else begin
                  bcnt <= bcnt_nx;
                  st   <= DS_SHIFT;
               end
            end
         end
      end
   end

   assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);

   assert_valid_from_tick_R4: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> $past(tick));

   assert_word_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !valid_o |-> ($stable(word_o) && $stable(chan_o)));

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      frame_err_o |=> frame_err_o);

   assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(frame_err_o) |-> $past(sel_edge));

   assert_edge_no_word_R7: assert property (@(posedge clk) disable iff (rst)
      sel_edge |=> !valid_o);

endmodule

// File: rtl/lrsel_audio_rx.sv
module lrsel_audio_rx #(
   parameter int unsigned WORD_BITS   = 32,
   parameter int unsigned BIT_CLKS    = 17,
   parameter int unsigned SAMPLE_POS  = 6,
   parameter int unsigned SKIP_BITS   = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 lr_in,
   input  logic                 dat_in,
   output logic [WORD_BITS-1:0] word_o,
   output logic                 chan_o,
   output logic                 valid_o,
   output logic                 frame_err_o
);

   logic [1:0] pins_s;
   logic       lr_s;
   logic       dat_s;
   logic       lr_d;
   logic       sel_edge;
   logic       tick;

   lrrx_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (2)
   ) u_sync (
      .clk   (clk),
      .d_in  ({lr_in, dat_in}),
      .q_out (pins_s)
   );

   assign lr_s  = pins_s[1];
   assign dat_s = pins_s[0];

   always_ff @(posedge clk) begin
      lr_d <= lr_s;
   end

   assign sel_edge = lr_s ^ lr_d;

   lrrx_phase #(
      .BIT_CLKS   (BIT_CLKS),
      .SAMPLE_POS (SAMPLE_POS)
   ) u_phase (
      .clk      (clk),
      .rst      (rst),
      .sel_edge (sel_edge),
      .tick     (tick)
   );

   lrrx_deser #(
      .WORD_BITS (WORD_BITS),
      .SKIP_BITS (SKIP_BITS)
   ) u_deser (
      .clk         (clk),
      .rst         (rst),
      .sel_edge    (sel_edge),
      .tick        (tick),
      .bit_in      (dat_s),
      .lvl_in      (lr_s),
      .word_o      (word_o),
      .chan_o      (chan_o),
      .valid_o     (valid_o),
      .frame_err_o (frame_err_o)
   );

endmodule

// File: tb/lrsel_audio_rx_tb.sv
module lrsel_audio_rx_tb;

   localparam int CLK_PER = 20;
   localparam int WB      = 32;
   localparam int BC      = 17;
   localparam int SP      = 6;
   localparam int SK      = 3;

   typedef struct packed {
      logic          v;
      logic [WB-1:0] w;
      logic          c;
      logic          e;
   } snap_t;

   typedef struct packed {
      logic          c;
      logic [WB-1:0] w;
   } got_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          lr_in = 1'b0;
   logic          dat_in = 1'b0;
   logic [WB-1:0] word_o;
   logic          chan_o;
   logic          valid_o;
   logic          frame_err_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_PER/2) clk = ~clk;

   lrsel_audio_rx u_dut (
      .clk         (clk),
      .rst         (rst),
      .lr_in       (lr_in),
      .dat_in      (dat_in),
      .word_o      (word_o),
      .chan_o      (chan_o),
      .valid_o     (valid_o),
      .frame_err_o (frame_err_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- pin-level reference model ----------------
   snap_t         pipe[$];
   snap_t         cur;
   snap_t         exp_s;
   bit            cmp_en = 0;
   logic          m_prev;
   bit            m_armed;
   int            m_cyc, m_next, m_j, m_bcnt;
   bit            m_coll;
   logic [WB-1:0] m_sh;
   logic          m_wch;

   always @(posedge clk) begin
      cmp_en = 1;
      if (rst) begin
         cur = '0;
         pipe = {};
         pipe.push_back('0);
         pipe.push_back('0);
         exp_s = '0;
         m_armed = 0; m_coll = 0; m_bcnt = 0; m_j = 0; m_cyc = 0; m_next = 0;
         m_sh = '0; m_wch = 1'b0;
         m_prev = lr_in;
      end else begin
         cur.v = 1'b0;
         if (lr_in != m_prev) begin
            if (m_coll && !(SK > 0 && m_bcnt == WB - SK)) begin
               m_coll = 0;
               m_bcnt = 0;
               cur.e  = 1'b1;
            end
            m_j = 0;
            m_armed = 1;
            m_next = m_cyc + SP;
         end else if (m_armed && m_cyc == m_next) begin
            m_next = m_next + BC;
            if (!m_coll && m_j == SK) begin
               m_coll = 1;
               m_bcnt = 0;
               m_wch = lr_in;
            end
            if (m_coll) begin
               m_sh = {m_sh[WB-2:0], dat_in};
               m_bcnt++;
               if (m_bcnt == WB) begin
                  cur.v = 1'b1;
                  cur.w = m_sh;
                  cur.c = m_wch;
                  m_coll = 0;
                  m_bcnt = 0;
               end
            end
            m_j++;
         end
         m_prev = lr_in;
         m_cyc++;
         pipe.push_back(cur);
         exp_s = pipe.pop_front();
      end
   end

   // every-cycle comparison, away from the active edge (R4)
   got_t got[$];
   always @(negedge clk) begin
      if (cmp_en) begin
         check({valid_o, word_o, chan_o, frame_err_o} == exp_s, "R4",
               "cycle compare {v,word,chan,err}",
               {29'd0, valid_o, word_o, chan_o, frame_err_o},
               {29'd0, exp_s});
      end
      if (valid_o) got.push_back({chan_o, word_o});
   end

   // ---------------- stimulus ----------------
   function automatic logic [WB-1:0] word_at(input int s, input int w);
      return (32'(w + 1) * 32'h9E37_79B9) ^ (32'(s) * 32'h7F4A_7C15);
   endfunction

   function automatic logic bit_at(input int s, input int b);
      logic [WB-1:0] x;
      if (b < SK) return logic'(b & 1);
      x = word_at(s, (b - SK) / WB);
      return x[WB - 1 - ((b - SK) % WB)];
   endfunction

   task automatic play(input int seed, input int eofs, input int nslots,
                       input int short_idx, input int short_len, input int tail_len);
      int bidx = 0;
      for (int s = 0; s <= nslots; s++) begin
         int len = (s == nslots) ? tail_len : ((s == short_idx) ? short_len : WB);
         for (int i = 0; i < len; i++) begin
            for (int c = 0; c < BC; c++) begin
               @(negedge clk);
               dat_in = bit_at(seed, bidx);
               if (i == 0 && c == eofs) lr_in = ~lr_in;
            end
            bidx++;
         end
      end
   endtask

   task automatic idle(input int n, input bit wiggle);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         dat_in = wiggle ? ~dat_in : 1'b0;
      end
   endtask

   task automatic check_words(input int seed, input int n, input logic l0, input string tag);
      for (int w = 0; w < n && w < got.size(); w++) begin
         check(got[w].w == word_at(seed, w), tag, $sformatf("word %0d value", w),
               64'(got[w].w), 64'(word_at(seed, w)));
         check(got[w].c == ((w % 2 == 0) ? ~l0 : l0), "R5", $sformatf("word %0d channel", w),
               64'(got[w].c), 64'((w % 2 == 0) ? ~l0 : l0));
      end
   endtask

   initial begin
      logic l0;
      repeat (4) @(negedge clk);
      // R6: reset values
      check(valid_o == 1'b0, "R6", "valid in reset", 64'(valid_o), 64'd0);
      check(word_o == '0, "R6", "word in reset", 64'(word_o), 64'd0);
      check(chan_o == 1'b0, "R6", "chan in reset", 64'(chan_o), 64'd0);
      check(frame_err_o == 1'b0, "R6", "err in reset", 64'(frame_err_o), 64'd0);
      rst = 1'b0;

      // R6: data activity without any select change gives no word
      idle(300, 1'b1);
      check(got.size() == 0, "R6", "words before first select change", 64'(got.size()), 64'd0);

      // R1 R2 R3 R8: clean slots, edge 3 clocks into the bit, long final slot
      l0 = lr_in;
      play(1, 3, 8, -1, 0, 80);
      idle(120, 1'b0);
      check(got.size() == 9, "R8", "word count with long last slot", 64'(got.size()), 64'd9);
      check_words(1, 9, l0, "R1 R2 R3");
      check(frame_err_o == 1'b0, "R7", "no error on clean stream", 64'(frame_err_o), 64'd0);

      // R1: different edge position inside the bit window, new realignment
      got.delete();
      l0 = lr_in;
      play(2, 1, 4, -1, 0, 40);
      idle(120, 1'b0);
      check(got.size() == 5, "R1", "word count at edge offset 1", 64'(got.size()), 64'd5);
      check_words(2, 5, l0, "R1 R3");

      // R7: short slot drops the partial word and raises the flag
      got.delete();
      l0 = lr_in;
      play(3, 3, 5, 2, 10, 40);
      idle(120, 1'b0);
      check(frame_err_o == 1'b1, "R7", "error after short slot", 64'(frame_err_o), 64'd1);
      check(got.size() == 5, "R7", "words with one dropped", 64'(got.size()), 64'd5);
      check_words(3, 2, l0, "R7");

      // R7: flag stays set while clean traffic decodes again
      got.delete();
      l0 = lr_in;
      play(4, 3, 3, -1, 0, 40);
      idle(120, 1'b0);
      check(frame_err_o == 1'b1, "R7", "error flag sticky", 64'(frame_err_o), 64'd1);
      check(got.size() == 4, "R7", "words after recovery", 64'(got.size()), 64'd4);
      check_words(4, 4, l0, "R2");

      // R6: reset clears the flag and outputs, then decoding restarts
      @(negedge clk);
      rst = 1'b1;
      repeat (4) @(negedge clk);
      check(frame_err_o == 1'b0, "R6", "err cleared by reset", 64'(frame_err_o), 64'd0);
      check(word_o == '0, "R6", "word cleared by reset", 64'(word_o), 64'd0);
      rst = 1'b0;
      idle(60, 1'b1);
      got.delete();
      l0 = lr_in;
      play(5, 3, 1, -1, 0, 40);
      idle(120, 1'b0);
      check(got.size() == 2, "R6", "words after reset", 64'(got.size()), 64'd2);
      check_words(5, 2, l0, "R3");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PER * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R4 watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule